// File: doc/BRIEF.md
# Gate Driver Fault Latch and Clear Timer

This block is the central protection controller of a six-output half-bridge gate driver. It watches a digital over-current comparator output, a logic-supply undervoltage flag and the filtered enable input. From these it drives three outputs: an active-low fault indication that feeds an open-drain pad, a global gate shutdown that goes to the dead-time stage, and a soft turn-off request for the three low-side drivers. Over-current must persist through a blanking window before it counts, so short spikes are rejected.

Once a fault is taken, all gates are killed and a clear timer starts. The fault is released only when the timer has expired and the cause is gone. If the cause is still present when the timer expires, the fault stays latched, and a full new timer period starts once the cause clears. A low enable shuts the gates after a qualification delay but does not raise the fault indication. The analog comparators and the RC clear network are replaced by clocked counters whose lengths are parameters in clock cycles. A power-on reset puts the block in the fault state with the timer starting, so the gates stay off for one clear period after power-up.

Top module: `fault_guard`

## Requirements
- R1: While por_n is low, fault_n is 0 and gate_kill and lowside_soft_off are 1; after release with no cause present, fault_n returns to 1 on exactly the CLEAR_CYCLES-th rising edge.
- R2: An oc_trip pulse sampled high on fewer than BLANK_CYCLES consecutive rising edges has no effect on fault_n, gate_kill or lowside_soft_off.
- R3: When oc_trip is sampled high on BLANK_CYCLES consecutive edges, fault_n goes to 0 on the next rising edge, whatever oc_trip does on that edge.
- R4: supply_uv sampled high while no fault is active sets fault_n to 0 on that same rising edge.
- R5: A fault whose cause is gone before the timer expires keeps fault_n at 0 for exactly CLEAR_CYCLES rising edges counted from the edge that took the fault.
- R6: If the cause is still present when the timer expires, fault_n stays 0; after the cause is sampled absent, fault_n returns to 1 exactly CLEAR_CYCLES edges after that edge.
- R7: If the cause returns while that restarted timer runs, the fault is held again and a full new CLEAR_CYCLES period starts on the edge that samples the cause absent.
- R8: drive_en sampled low on EN_DELAY_CYCLES consecutive edges sets gate_kill to 1 on the last of them, with fault_n staying 1 and lowside_soft_off 0; drive_en sampled high clears that shutdown on the same edge.
- R9: A drive_en low pulse shorter than EN_DELAY_CYCLES edges leaves gate_kill at 0.
- R10: lowside_soft_off is 1 exactly while fault_n is 0, and gate_kill is 1 whenever fault_n is 0.
- R11: A cause that appears and vanishes during the first timer period does not extend the fault beyond CLEAR_CYCLES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| oc_trip | input | 1 | Over-current comparator output, synchronous, active high |
| supply_uv | input | 1 | Logic-supply undervoltage flag, synchronous, active high |
| drive_en | input | 1 | Filtered enable, high lets the gates run |
| fault_n | output | 1 | Fault indication, low while a fault is latched |
| gate_kill | output | 1 | Shutdown of all six gate outputs to the dead-time stage |
| lowside_soft_off | output | 1 | Request for soft turn-off of the low-side drivers |

## Verification
The bench goes after the off-by-one edges: an over-current pulse one cycle short of the blanking window, which a design counting one too few would trip on, and the exact edge on which the fault releases, which a timer with a wrong terminal count would move by a cycle. It holds the undervoltage flag across the timer expiry, where a design that released on the timer alone would raise the fault line while the supply is still low, and then brings the cause back during the restarted period, where a design that kept counting instead of restarting would release early. Enable pulses just below and at the shutdown delay catch a design that qualifies enable wrongly or lets enable drive the fault line.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE         = 2'd0,
    ST_FAULT_ACTIVE = 2'd1,
    ST_HELD         = 2'd2,
    ST_CLEARING     = 2'd3
  } guardState_t;

  // control -> datapath
  typedef struct packed {
    logic timerLoad;
    logic timerRun;
  } guardStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic ocQual;
    logic enKill;
    logic timerDone;
  } guardFlags_t;

endpackage

// File: rtl/fault_guard_runcnt.sv
module fault_guard_runcnt #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic porN,
  input  logic level,
  output logic qualified
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] runCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               runCnt <= '0;
    else if (!level)         runCnt <= '0;
    else if (runCnt != LIM)  runCnt <= runCnt + 1'b1;
  end

  assign qualified = (runCnt == LIM);

  // a low level always drops the qualification on the next edge
  p_run_reset_r2_r9: assert property (@(posedge clk) disable iff (!porN)
    !level |=> !qualified);

endmodule

// File: rtl/fault_guard_dp.sv
module fault_guard_dp
  import fault_guard_pkg::*;
#(
  parameter int BLANK_CYCLES    = 60,
  parameter int EN_DELAY_CYCLES = 100,
  parameter int CLEAR_CYCLES    = 260000
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         ocIn,
  input  logic         enIn,
  input  guardStrobe_t strobe,
  output guardFlags_t  flags
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_CYCLES - 1);

  logic ocQual;
  logic enKill;
  logic [CW-1:0] timerCnt;

  fault_guard_runcnt #(.LIMIT(BLANK_CYCLES)) uBlank (
    .clk(clk), .porN(porN), .level(ocIn), .qualified(ocQual)
  );

  fault_guard_runcnt #(.LIMIT(EN_DELAY_CYCLES)) uEnDelay (
    .clk(clk), .porN(porN), .level(!enIn), .qualified(enKill)
  );

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                      timerCnt <= '0;
    else if (strobe.timerLoad)                      timerCnt <= '0;
    else if (strobe.timerRun && timerCnt != CLR_LAST) timerCnt <= timerCnt + 1'b1;
  end

  always_comb begin
    flags.ocQual    = ocQual;
    flags.enKill    = enKill;
    flags.timerDone = strobe.timerRun && (timerCnt == CLR_LAST);
  end

  // enable seen high always removes the enable shutdown
  p_en_release_r8: assert property (@(posedge clk) disable iff (!porN)
    enIn |=> !flags.enKill);

endmodule

// File: rtl/fault_guard_ctl.sv
module fault_guard_ctl
  import fault_guard_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         uvIn,
  input  guardFlags_t  flags,
  output guardStrobe_t strobe,
  output logic         faultN,
  output logic         gateKill,
  output logic         softOff
);
  guardState_t state, stateNext;
  logic cause;

  assign cause = uvIn | flags.ocQual;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:         if (cause) stateNext = ST_FAULT_ACTIVE;
      ST_FAULT_ACTIVE: if (flags.timerDone) stateNext = cause ? ST_HELD : ST_IDLE;
      ST_HELD:         if (!cause) stateNext = ST_CLEARING;
      ST_CLEARING: begin
        if (cause)                 stateNext = ST_HELD;
        else if (flags.timerDone)  stateNext = ST_IDLE;
      end
      default:         stateNext = ST_FAULT_ACTIVE;
    endcase
  end

  always_comb begin
    strobe.timerRun  = (state == ST_FAULT_ACTIVE) || (state == ST_CLEARING);
    strobe.timerLoad = ((state == ST_IDLE) && cause) || ((state == ST_HELD) && !cause);
  end

  // power-up starts latched with the clear timer running
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_FAULT_ACTIVE;
    else       state <= stateNext;
  end

  assign faultN   = (state == ST_IDLE);
  assign softOff  = !faultN;
  assign gateKill = softOff | flags.enKill;

  p_uv_trips_r4: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_IDLE && uvIn) |=> (state == ST_FAULT_ACTIVE));

  p_hold_while_cause_r6: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_HELD && cause) |=> (state == ST_HELD));

  p_release_after_timer_r5: assert property (@(posedge clk) disable iff (!porN)
    (state != ST_IDLE && !flags.timerDone) |=> (state != ST_IDLE));

endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fault_guard_pkg::*;
#(
  parameter int BLANK_CYCLES    = 60,
  parameter int EN_DELAY_CYCLES = 100,
  parameter int CLEAR_CYCLES    = 260000
) (
  input  logic clk,
  input  logic por_n,
  input  logic oc_trip,
  input  logic supply_uv,
  input  logic drive_en,
  output logic fault_n,
  output logic gate_kill,
  output logic lowside_soft_off
);
  guardStrobe_t strobe;
  guardFlags_t  flags;

  fault_guard_dp #(
    .BLANK_CYCLES(BLANK_CYCLES),
    .EN_DELAY_CYCLES(EN_DELAY_CYCLES),
    .CLEAR_CYCLES(CLEAR_CYCLES)
  ) uDp (
    .clk(clk), .porN(por_n), .ocIn(oc_trip), .enIn(drive_en),
    .strobe(strobe), .flags(flags)
  );

  fault_guard_ctl uCtl (
    .clk(clk), .porN(por_n), .uvIn(supply_uv), .flags(flags),
    .strobe(strobe), .faultN(fault_n), .gateKill(gate_kill),
    .softOff(lowside_soft_off)
  );

  // R10: a latched fault always comes with shutdown and soft-off request
  p_fault_outputs_r10: assert property (@(posedge clk) disable iff (!por_n)
    !fault_n |-> (gate_kill && lowside_soft_off));

endmodule

// File: tb/fault_guard_test.sv
module fault_guard_test;
  localparam int B = 6;
  localparam int E = 10;
  localparam int C = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic oc_trip = 1'b0, supply_uv = 1'b0, drive_en = 1'b1;
  logic fault_n, gate_kill, lowside_soft_off;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_guard #(.BLANK_CYCLES(B), .EN_DELAY_CYCLES(E), .CLEAR_CYCLES(C)) uut (
    .clk(clk), .por_n(por_n), .oc_trip(oc_trip), .supply_uv(supply_uv),
    .drive_en(drive_en), .fault_n(fault_n), .gate_kill(gate_kill),
    .lowside_soft_off(lowside_soft_off)
  );

  // behavioural reference: run lengths and a mode number
  int ocRun = 0, enRun = 0, mode = 1, timer = 0;

  always @(posedge clk) begin
    if (!por_n) begin
      ocRun = 0; enRun = 0; mode = 1; timer = 0;
    end else begin
      bit causeNow;
      causeNow = supply_uv || (ocRun == B);
      case (mode)
        0: if (causeNow) begin mode = 1; timer = 0; end
        1: if (timer == C - 1) mode = causeNow ? 2 : 0; else timer++;
        2: if (!causeNow) begin mode = 3; timer = 0; end
        default: if (causeNow) mode = 2;
                 else if (timer == C - 1) mode = 0; else timer++;
      endcase
      ocRun = oc_trip ? ((ocRun < B) ? ocRun + 1 : B) : 0;
      enRun = !drive_en ? ((enRun < E) ? enRun + 1 : E) : 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    bit expF, expK, expS;
    expF = (mode == 0);
    expK = (mode != 0) || (enRun == E);
    expS = (mode != 0);
    check(fault_n == expF, "R5 model fault_n", fault_n, expF);
    check(gate_kill == expK, "R8 model gate_kill", gate_kill, expK);
    check(lowside_soft_off == expS, "R10 model soft_off", lowside_soft_off, expS);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    check(fault_n == 0, "R1 reset fault_n", fault_n, 0);
    check(gate_kill == 1, "R1 reset gate_kill", gate_kill, 1);
    check(lowside_soft_off == 1, "R1 reset soft_off", lowside_soft_off, 1);
    por_n = 1'b1;
    step(C - 1);
    check(fault_n == 0, "R1 still held", fault_n, 0);
    step(1);
    check(fault_n == 1, "R1 released", fault_n, 1);
    check(gate_kill == 0, "R1 gates free", gate_kill, 0);
    step(3);

    // R2: one cycle short of the blanking window
    oc_trip = 1'b1; step(B - 1);
    oc_trip = 1'b0; step(3);
    check(fault_n == 1, "R2 short spike ignored", fault_n, 1);
    check(gate_kill == 0, "R2 no kill", gate_kill, 0);

    // R3: full window trips on the following edge
    oc_trip = 1'b1; step(B);
    check(fault_n == 1, "R3 not before window", fault_n, 1);
    oc_trip = 1'b0; step(1);
    check(fault_n == 0, "R3 tripped", fault_n, 0);
    check(gate_kill == 1, "R10 kill with fault", gate_kill, 1);
    check(lowside_soft_off == 1, "R10 soft with fault", lowside_soft_off, 1);
    step(C - 1);
    check(fault_n == 0, "R5 held to last edge", fault_n, 0);
    step(1);
    check(fault_n == 1, "R5 released", fault_n, 1);
    check(lowside_soft_off == 0, "R10 soft cleared", lowside_soft_off, 0);
    step(2);

    // R4 / R6: undervoltage outlasting the timer
    supply_uv = 1'b1; step(1);
    check(fault_n == 0, "R4 uv trips", fault_n, 0);
    step(C + 5);
    check(fault_n == 0, "R6 held past expiry", fault_n, 0);
    supply_uv = 1'b0; step(1);
    step(C - 1);
    check(fault_n == 0, "R6 restarted timer running", fault_n, 0);
    step(1);
    check(fault_n == 1, "R6 released", fault_n, 1);
    step(2);

    // R7: cause returns during the restarted timer
    supply_uv = 1'b1; step(C + 1);
    supply_uv = 1'b0; step(6);
    supply_uv = 1'b1; step(1);
    supply_uv = 1'b0; step(1);
    step(C - 1);
    check(fault_n == 0, "R7 full restart", fault_n, 0);
    step(1);
    check(fault_n == 1, "R7 released", fault_n, 1);
    step(2);

    // R11: brief causes inside the first period do not extend it
    supply_uv = 1'b1; step(1);
    supply_uv = 1'b0; step(5);
    supply_uv = 1'b1; step(1);
    supply_uv = 1'b0; step(C - 1 - 6);
    check(fault_n == 0, "R11 held", fault_n, 0);
    step(1);
    check(fault_n == 1, "R11 not extended", fault_n, 1);
    step(2);

    // R9: enable low pulse one short
    drive_en = 1'b0; step(E - 1);
    check(gate_kill == 0, "R9 short enable low", gate_kill, 0);
    drive_en = 1'b1; step(1);
    check(gate_kill == 0, "R9 no kill", gate_kill, 0);
    step(2);

    // R8: enable low for the full delay
    drive_en = 1'b0; step(E);
    check(gate_kill == 1, "R8 enable kill", gate_kill, 1);
    check(fault_n == 1, "R8 no fault from enable", fault_n, 1);
    check(lowside_soft_off == 0, "R8 no soft-off", lowside_soft_off, 0);
    drive_en = 1'b1; step(1);
    check(gate_kill == 0, "R8 enable release", gate_kill, 0);
    step(3);

    finish_run();
  end
endmodule